// File: doc/BRIEF.md
# Cipher Key and Crypt-Mode Controller

This block sits beside the decode and writeback stages of a 32-bit five-stage pipeline that can run encrypted code. It holds a 64-bit cipher key and a single crypt-enable flag, and supplies both to the cipher engines in the fetch and memory stages. Two load-type instructions fill the key one 32-bit half at a time. The loaded word reaches the block as writeback data, tagged with the opcode of the instruction that produced it. A jump-format mode instruction, seen at decode, turns encryption on or off according to whether its 26-bit operand field is zero.

The cipher engines need the key to be settled before the mode changes. For that reason the block holds back a mode instruction that arrives in the same cycle as an accepted key write, or in either of the two cycles after it. It does this by raising a stall output while the instruction waits. While encryption is on, key writes are refused, so the key stays fixed for the rest of an encrypted program run. All opcodes and the settle gap are parameters.

Top module: `keyctl`

## Requirements
- R1: After reset the key output is all zeros, crypt-enable is 0 and stall is 0.
- R2: When wb_valid is 1, wb_opcode equals the lower-load opcode (default 6'h38) and crypt-enable is 0, key bits 31:0 take wb_data on the next cycle and key bits 63:32 stay unchanged.
- R3: When wb_valid is 1, wb_opcode equals the upper-load opcode (default 6'h39) and crypt-enable is 0, key bits 63:32 take wb_data on the next cycle and key bits 31:0 stay unchanged.
- R4: A writeback with wb_valid at 0, or with any opcode other than the two load opcodes, leaves the key unchanged.
- R5: A mode instruction is one with instr_valid at 1 and instr_word bits 31:26 equal to the mode opcode (default 6'h3A). When it is not stalled, crypt-enable on the next cycle is 1 if instr_word bits 25:0 are nonzero and 0 if they are all zero.
- R6: Crypt-enable does not change unless an unstalled mode instruction is presented; instr_valid at 0 or any other opcode has no effect on it.
- R7: stall_o rises in the same cycle as a mode instruction that coincides with an accepted key write or arrives one or two cycles after it, and crypt-enable then keeps its value. The same mode instruction presented three cycles after the write is accepted.
- R8: stall_o is 0 in every cycle in which no mode instruction is presented.
- R9: While crypt-enable is 1, key-load writebacks are ignored: the key keeps its value and no settle window starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Decode-stage instruction is valid |
| instr_word | input | 32 | Decode-stage instruction word |
| wb_valid | input | 1 | Writeback result is valid |
| wb_opcode | input | 6 | Opcode of the instruction in writeback |
| wb_data | input | 32 | Loaded memory word in writeback |
| key_o | output | 64 | Current cipher key |
| crypt_en_o | output | 1 | Encryption enabled flag |
| stall_o | output | 1 | Hold the decode-stage mode instruction |

## Verification
The bound checker enforces the following relations every cycle: half-select key updates, key hold whenever no write is accepted (this covers the lock while encryption is on), crypt-enable following the operand of each accepted mode instruction, and the stall decision, which it compares with its own count of cycles since the last accepted write. The reset values, and the exact points in the sequence where a held mode instruction goes through, show up only in the bench's scenarios. Those scenarios are: stalls at offsets zero, one and two followed by acceptance at three; a write colliding with a mode instruction; and operands that are nonzero only in the top bit or only in the bottom bit.

// File: rtl/keyctl_pkg.sv
package keyctl_pkg;

    // Which half of the key a writeback targets
    typedef enum logic [1:0] {
        KSEL_NONE = 2'd0,
        KSEL_LO   = 2'd1,
        KSEL_HI   = 2'd2
    } keysel_e;

endpackage

// File: rtl/keyctl_decode.sv
module keyctl_decode
    import keyctl_pkg::*;
#(
    parameter int         INSTR_W  = 32,
    parameter int         OPC_W    = 6,
    parameter logic [5:0] OPC_LO   = 6'h38,
    parameter logic [5:0] OPC_HI   = 6'h39,
    parameter logic [5:0] OPC_MODE = 6'h3A
) (
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic               wb_valid,
    input  logic [OPC_W-1:0]   wb_opcode,
    output keysel_e            wb_sel,
    output logic               mode_hit,
    output logic               mode_on
);
    localparam int FIELD_W = INSTR_W - OPC_W;

    logic [OPC_W-1:0]   id_opc;
    logic [FIELD_W-1:0] id_field;

    assign id_opc   = instr_word[INSTR_W-1:FIELD_W];
    assign id_field = instr_word[FIELD_W-1:0];

    always_comb begin
        wb_sel = KSEL_NONE;
        if (wb_valid) begin
            if (wb_opcode == OPC_W'(OPC_LO))      wb_sel = KSEL_LO;
            else if (wb_opcode == OPC_W'(OPC_HI)) wb_sel = KSEL_HI;
        end
    end

    assign mode_hit = instr_valid && (id_opc == OPC_W'(OPC_MODE));
    assign mode_on  = |id_field;

endmodule

// File: rtl/keyctl_settle.sv
module keyctl_settle #(
    parameter int GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic busy
);
    localparam int CNT_W = $clog2(GAP + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } settle_t;

    settle_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arm)                st_d.cnt = CNT_W'(GAP);
        else if (st_q.cnt != 0) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.cnt != 0);

endmodule

// File: rtl/keyctl.sv
module keyctl
    import keyctl_pkg::*;
#(
    parameter int         INSTR_W  = 32,
    parameter int         OPC_W    = 6,
    parameter int         KEY_W    = 64,
    parameter int         GAP      = 2,
    parameter logic [5:0] OPC_LO   = 6'h38,
    parameter logic [5:0] OPC_HI   = 6'h39,
    parameter logic [5:0] OPC_MODE = 6'h3A
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [INSTR_W-1:0]   instr_word,
    input  logic                 wb_valid,
    input  logic [OPC_W-1:0]     wb_opcode,
    input  logic [KEY_W/2-1:0]   wb_data,
    output logic [KEY_W-1:0]     key_o,
    output logic                 crypt_en_o,
    output logic                 stall_o
);
    localparam int HALF_W = KEY_W / 2;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic             crypt;
    } ctl_t;

    ctl_t    ctl_d, ctl_q;
    keysel_e wb_sel;
    logic    mode_hit, mode_on;
    logic    wr_acc, settle_busy;

    keyctl_decode #(
        .INSTR_W (INSTR_W),
        .OPC_W   (OPC_W),
        .OPC_LO  (OPC_LO),
        .OPC_HI  (OPC_HI),
        .OPC_MODE(OPC_MODE)
    ) u_dec (
        .instr_valid(instr_valid),
        .instr_word (instr_word),
        .wb_valid   (wb_valid),
        .wb_opcode  (wb_opcode),
        .wb_sel     (wb_sel),
        .mode_hit   (mode_hit),
        .mode_on    (mode_on)
    );

    keyctl_settle #(
        .GAP(GAP)
    ) u_settle (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (wr_acc),
        .busy (settle_busy)
    );

    // Key writes are refused while encryption runs
    assign wr_acc  = (wb_sel != KSEL_NONE) && !ctl_q.crypt;
    assign stall_o = mode_hit && (wr_acc || settle_busy);

    always_comb begin
        ctl_d = ctl_q;
        if (wr_acc) begin
            if (wb_sel == KSEL_LO) ctl_d.key[HALF_W-1:0]     = wb_data;
            else                   ctl_d.key[KEY_W-1:HALF_W] = wb_data;
        end
        if (mode_hit && !stall_o) ctl_d.crypt = mode_on;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign key_o      = ctl_q.key;
    assign crypt_en_o = ctl_q.crypt;

endmodule

// File: rtl/keyctl_chk.sv
module keyctl_chk #(
    parameter int         INSTR_W  = 32,
    parameter int         OPC_W    = 6,
    parameter int         KEY_W    = 64,
    parameter int         GAP      = 2,
    parameter logic [5:0] OPC_LO   = 6'h38,
    parameter logic [5:0] OPC_HI   = 6'h39,
    parameter logic [5:0] OPC_MODE = 6'h3A
) (
    input logic               clk,
    input logic               rst_n,
    input logic               instr_valid,
    input logic [INSTR_W-1:0] instr_word,
    input logic               wb_valid,
    input logic [OPC_W-1:0]   wb_opcode,
    input logic [KEY_W/2-1:0] wb_data,
    input logic [KEY_W-1:0]   key_o,
    input logic               crypt_en_o,
    input logic               stall_o
);
    localparam int HALF_W  = KEY_W / 2;
    localparam int FIELD_W = INSTR_W - OPC_W;
    localparam int SW      = $clog2(GAP + 2);

    logic is_lo, is_hi, acc, mode;
    logic [SW-1:0] since_q;

    assign is_lo = wb_valid && (wb_opcode == OPC_W'(OPC_LO));
    assign is_hi = wb_valid && (wb_opcode == OPC_W'(OPC_HI));
    assign acc   = (is_lo || is_hi) && !crypt_en_o;
    assign mode  = instr_valid && (instr_word[INSTR_W-1:FIELD_W] == OPC_W'(OPC_MODE));

    // Cycles since the last accepted key write, 0 meaning none recently
    always_ff @(posedge clk) begin
        if (!rst_n)                         since_q <= '0;
        else if (acc)                       since_q <= SW'(1);
        else if (since_q != 0 && since_q <= SW'(GAP)) since_q <= since_q + 1'b1;
    end

    // R2
    lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && is_lo |=> key_o[HALF_W-1:0] == $past(wb_data)
                     && key_o[KEY_W-1:HALF_W] == $past(key_o[KEY_W-1:HALF_W]));

    // R3
    hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && is_hi |=> key_o[KEY_W-1:HALF_W] == $past(wb_data)
                     && key_o[HALF_W-1:0] == $past(key_o[HALF_W-1:0]));

    // R4 R9
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(key_o));

    // R5
    mode_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode && !stall_o |=> crypt_en_o == $past(|instr_word[FIELD_W-1:0]));

    // R6
    crypt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode && !stall_o) |=> $stable(crypt_en_o));

    // R7
    stall_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode |-> stall_o == (acc || (since_q != 0 && since_q <= SW'(GAP))));

    // R8
    stall_only_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |-> !stall_o);

endmodule

bind keyctl keyctl_chk #(
    .INSTR_W (INSTR_W),
    .OPC_W   (OPC_W),
    .KEY_W   (KEY_W),
    .GAP     (GAP),
    .OPC_LO  (OPC_LO),
    .OPC_HI  (OPC_HI),
    .OPC_MODE(OPC_MODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_valid(instr_valid),
    .instr_word (instr_word),
    .wb_valid   (wb_valid),
    .wb_opcode  (wb_opcode),
    .wb_data    (wb_data),
    .key_o      (key_o),
    .crypt_en_o (crypt_en_o),
    .stall_o    (stall_o)
);

// File: tb/keyctl_test.sv
module keyctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        wb_valid = 1'b0;
    logic [5:0]  wb_opcode = '0;
    logic [31:0] wb_data = '0;
    logic [63:0] key_o;
    logic        crypt_en_o;
    logic        stall_o;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [63:0] m_key = '0;
    logic        m_crypt = 1'b0;
    int          m_since = 0;

    localparam logic [5:0] LO = 6'h38, HI = 6'h39, MD = 6'h3A;

    always #4 clk = ~clk;

    keyctl uut (
        .clk(clk), .rst_n(rst_n),
        .instr_valid(instr_valid), .instr_word(instr_word),
        .wb_valid(wb_valid), .wb_opcode(wb_opcode), .wb_data(wb_data),
        .key_o(key_o), .crypt_en_o(crypt_en_o), .stall_o(stall_o)
    );

    task automatic chk1(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s key actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check stall, clock, update model, check state
    task automatic cyc(input logic iv, input logic [31:0] iw,
                       input logic wv, input logic [5:0] wo, input logic [31:0] wd,
                       input string ktag, input string ctag);
        logic acc, mhit, exp_stall;
        instr_valid = iv; instr_word = iw;
        wb_valid = wv; wb_opcode = wo; wb_data = wd;
        #1;
        acc  = wv && (wo == LO || wo == HI) && !m_crypt;
        mhit = iv && (iw[31:26] == MD);
        exp_stall = mhit && (acc || (m_since >= 1 && m_since <= 2));
        chk1(mhit ? "R7" : "R8", stall_o, exp_stall, "stall");
        @(posedge clk);
        if (acc) begin
            if (wo == LO) m_key[31:0] = wd;
            else          m_key[63:32] = wd;
            m_since = 1;
        end else if (m_since >= 1 && m_since <= 2) begin
            m_since++;
        end else begin
            m_since = 0;
        end
        if (mhit && !exp_stall) m_crypt = |iw[25:0];
        @(negedge clk);
        chk64(ktag, key_o, m_key);
        chk1(ctag, crypt_en_o, m_crypt, "crypt_en");
    endtask

    task automatic idle(input string ktag, input string ctag);
        cyc(1'b0, '0, 1'b0, '0, '0, ktag, ctag);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state held in reset
        chk64("R1", key_o, 64'd0);
        chk1("R1", crypt_en_o, 1'b0, "crypt_en");
        chk1("R1", stall_o, 1'b0, "stall");
        rst_n = 1'b1;
        @(negedge clk);
        chk64("R1", key_o, 64'd0);
        chk1("R1", crypt_en_o, 1'b0, "crypt_en");

        // R4: invalid or foreign writebacks leave the key alone
        cyc(1'b0, '0, 1'b0, LO, 32'hDEAD_BEEF, "R4", "R6");
        cyc(1'b0, '0, 1'b1, 6'h23, 32'hCAFE_F00D, "R4", "R6");
        // R6: mode opcode with valid low, and foreign opcode with valid high
        cyc(1'b0, {MD, 26'd1}, 1'b0, '0, '0, "R4", "R6");
        cyc(1'b1, {6'h02, 26'd1}, 1'b0, '0, '0, "R4", "R6");

        // R2 then R3: load both halves
        cyc(1'b0, '0, 1'b1, LO, 32'hA5A5_0001, "R2", "R6");
        cyc(1'b0, '0, 1'b1, HI, 32'h1234_5678, "R3", "R6");
        // R7: mode at +1 and +2 stalls, at +3 accepted
        cyc(1'b1, {MD, 26'd1}, 1'b0, '0, '0, "R4", "R7");
        cyc(1'b1, {MD, 26'd1}, 1'b0, '0, '0, "R4", "R7");
        cyc(1'b1, {MD, 26'd1}, 1'b0, '0, '0, "R4", "R5");

        // R9: writes refused while encryption is on, no window opens
        cyc(1'b0, '0, 1'b1, LO, 32'h0BAD_0BAD, "R9", "R6");
        cyc(1'b0, '0, 1'b1, HI, 32'h0BAD_0BAD, "R9", "R6");
        // R5: zero operand disables, no stall since writes were refused
        cyc(1'b1, {MD, 26'd0}, 1'b0, '0, '0, "R9", "R5");

        // R7: write and mode in the same cycle
        cyc(1'b1, {MD, 26'd1}, 1'b1, LO, 32'h5555_AAAA, "R2", "R7");
        // R8: non-mode instructions inside the window do not stall
        cyc(1'b1, {6'h08, 26'h3FF_FFFF}, 1'b0, '0, '0, "R4", "R6");
        idle("R4", "R6");
        // R5: operand nonzero only in its top bit enables
        cyc(1'b1, {MD, 26'h200_0000}, 1'b0, '0, '0, "R4", "R5");
        cyc(1'b1, {MD, 26'd0}, 1'b0, '0, '0, "R4", "R5");
        // R5: operand nonzero only in bit 0 enables
        cyc(1'b1, {MD, 26'd1}, 1'b0, '0, '0, "R4", "R5");
        idle("R4", "R6");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule